// File: doc/BRIEF.md
# Compressed min-sum check node

This block is one parity check of a min-sum belief-propagation decoder. Every variable node joined to the check sends a message in sign-magnitude form: a separate sign bit and a magnitude with no sign bit in it. The measured syndrome bit for the check comes in alongside these messages. The node does not produce one outgoing message per edge. Instead it reduces all inputs to a single compressed tuple, which is broadcast to every neighbour. The tuple holds an overall parity, the index of the edge with the smallest magnitude, that smallest magnitude, and the second-smallest magnitude.

Each receiving variable node finishes its own exclusive minimum from the tuple. It takes the second-smallest magnitude when its edge is the selected one and the smallest otherwise. Scaling, offset correction and graph wiring belong to the surrounding decoder. Magnitudes pass through a padded binary tree of merge cells. Each cell combines two partial (smallest, second, index) triples. One register stage holds the result, so a tuple appears one clock after its inputs are sampled.

Top module: `minsum_chk_node`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0 and parity, selector, smallest and second magnitude are all zero, whatever `in_valid` does during reset.
- R2: A set of inputs sampled with `in_valid` high at a rising edge produces its tuple, with `out_valid` high, right after that edge. `out_valid` is high in no other cycle.
- R3: `out_parity` is the XOR of every sign bit `msg_sign[i]` (1 means negative) and `syndrome`.
- R4: `out_min1` is the smallest of the edge magnitudes. Edge i's magnitude is `msg_mag[i*MAG_W +: MAG_W]`.
- R5: `out_sel` is the index of the edge holding the smallest magnitude. When several edges share it, the lowest index is reported.
- R6: `out_min2` is the smallest magnitude among all edges other than the selected one. When the minimum is shared, `out_min2` equals `out_min1`.
- R7: Sign bits and the syndrome have no effect on `out_sel`, `out_min1` or `out_min2`.
- R8: In a cycle after an edge where `in_valid` was low, `out_valid` is 0 and the tuple fields keep their previous values.
- R9: When every magnitude is at full scale (all ones), `out_min1` and `out_min2` are full scale and `out_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are valid this cycle |
| msg_sign | input | DEGREE | Sign of each incoming message, bit i for edge i |
| msg_mag | input | DEGREE*MAG_W | Magnitudes, edge i in bits i*MAG_W upward |
| syndrome | input | 1 | Measured syndrome bit of this check |
| out_valid | output | 1 | Tuple registered this cycle |
| out_parity | output | 1 | XOR of all signs and the syndrome |
| out_sel | output | SEL_W | Index of the edge with the smallest magnitude |
| out_min1 | output | MAG_W | Smallest magnitude |
| out_min2 | output | MAG_W | Second-smallest magnitude |

## Verification
The following input patterns are used:
- Ascending, descending and mid-placed minima show whether the selector follows the minimum wherever it sits in the tree.
- A minimum on the last edge tests the padded leaves.
- Shared minima, all-equal inputs, all-zero inputs and all-full-scale inputs separate a correct lowest-index tie rule from a cell that prefers its right operand. They also show whether the second magnitude collapses onto the first as it should.
- The same magnitudes sent with flipped signs and syndrome must change only the parity.
- Back-to-back words mixed with idle gaps show whether the tuple holds between valid words.
- A long run of pseudo-random words follows. Some use a narrow magnitude range that forces frequent ties.

// File: rtl/chk_node_pkg.sv
package chk_node_pkg;

    // Width of an edge index for a node of the given degree (at least one bit).
    function automatic int sel_width(input int degree);
        return (degree <= 2) ? 1 : $clog2(degree);
    endfunction

    // Number of leaves of the padded merge tree.
    function automatic int tree_leaves(input int degree);
        return 1 << sel_width(degree);
    endfunction

endpackage

// File: rtl/cn_merge_cell.sv
// Combines two partial (smallest, second, index) triples. Operand a always
// covers lower edge indices than operand b, so a wins every tie.
module cn_merge_cell #(
    parameter int MAG_W = 5,
    parameter int SEL_W = 3
) (
    input  logic [MAG_W-1:0] a_min1,
    input  logic [MAG_W-1:0] a_min2,
    input  logic [SEL_W-1:0] a_idx,
    input  logic [MAG_W-1:0] b_min1,
    input  logic [MAG_W-1:0] b_min2,
    input  logic [SEL_W-1:0] b_idx,
    output logic [MAG_W-1:0] y_min1,
    output logic [MAG_W-1:0] y_min2,
    output logic [SEL_W-1:0] y_idx
);
    typedef struct packed {
        logic [MAG_W-1:0] lo;
        logic [MAG_W-1:0] nx;
        logic [SEL_W-1:0] ix;
    } part_t;

    part_t win, lose, res;
    logic  b_strict;

    always_comb begin
        b_strict = (b_min1 < a_min1);
        if (b_strict) begin
            win  = '{lo: b_min1, nx: b_min2, ix: b_idx};
            lose = '{lo: a_min1, nx: a_min2, ix: a_idx};
        end else begin
            win  = '{lo: a_min1, nx: a_min2, ix: a_idx};
            lose = '{lo: b_min1, nx: b_min2, ix: b_idx};
        end
        // Second place: the winner's runner-up or the loser's best.
        res.lo = win.lo;
        res.ix = win.ix;
        res.nx = (lose.lo < win.nx) ? lose.lo : win.nx;
    end

    assign y_min1 = res.lo;
    assign y_min2 = res.nx;
    assign y_idx  = res.ix;
endmodule

// File: rtl/cn_min_tree.sv
// Padded binary tree of merge cells, stored heap style: node k has
// children 2k (lower edges) and 2k+1 (higher edges); leaves sit at LEAVES+i.
module cn_min_tree
    import chk_node_pkg::*;
#(
    parameter int DEGREE = 6,
    parameter int MAG_W  = 5,
    parameter int SEL_W  = 3
) (
    input  logic [DEGREE*MAG_W-1:0] mag_flat,
    output logic [MAG_W-1:0]        min1,
    output logic [MAG_W-1:0]        min2,
    output logic [SEL_W-1:0]        sel
);
    localparam int LEAVES = 1 << SEL_W;
    localparam int NODES  = 2 * LEAVES;
    localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}};

    logic [MAG_W-1:0] n_min1 [1:NODES-1];
    logic [MAG_W-1:0] n_min2 [1:NODES-1];
    logic [SEL_W-1:0] n_idx  [1:NODES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < DEGREE) begin : g_real
            assign n_min1[LEAVES+i] = mag_flat[i*MAG_W +: MAG_W];
        end else begin : g_pad
            assign n_min1[LEAVES+i] = FULL;
        end
        assign n_min2[LEAVES+i] = FULL;
        assign n_idx[LEAVES+i]  = SEL_W'(i);
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_cell
        cn_merge_cell #(.MAG_W(MAG_W), .SEL_W(SEL_W)) u_cell (
            .a_min1 (n_min1[2*k]),
            .a_min2 (n_min2[2*k]),
            .a_idx  (n_idx[2*k]),
            .b_min1 (n_min1[2*k+1]),
            .b_min2 (n_min2[2*k+1]),
            .b_idx  (n_idx[2*k+1]),
            .y_min1 (n_min1[k]),
            .y_min2 (n_min2[k]),
            .y_idx  (n_idx[k])
        );
    end

    assign min1 = n_min1[1];
    assign min2 = n_min2[1];
    assign sel  = n_idx[1];
endmodule

// File: rtl/cn_parity.sv
// Overall check parity: the signs of all edges folded with the syndrome bit.
module cn_parity #(
    parameter int DEGREE = 6
) (
    input  logic [DEGREE-1:0] signs,
    input  logic              syndrome,
    output logic              parity
);
    assign parity = (^signs) ^ syndrome;
endmodule

// File: rtl/minsum_chk_node.sv
module minsum_chk_node
    import chk_node_pkg::*;
#(
    parameter int DEGREE = 6,
    parameter int MAG_W  = 5,
    localparam int SEL_W = sel_width(DEGREE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DEGREE-1:0]       msg_sign,
    input  logic [DEGREE*MAG_W-1:0] msg_mag,
    input  logic                    syndrome,
    output logic                    out_valid,
    output logic                    out_parity,
    output logic [SEL_W-1:0]        out_sel,
    output logic [MAG_W-1:0]        out_min1,
    output logic [MAG_W-1:0]        out_min2
);
    typedef struct packed {
        logic             parity;
        logic [SEL_W-1:0] sel;
        logic [MAG_W-1:0] min1;
        logic [MAG_W-1:0] min2;
    } tuple_t;

    tuple_t tup_d, tup_q;
    logic   vld_q;

    cn_parity #(.DEGREE(DEGREE)) u_par (
        .signs    (msg_sign),
        .syndrome (syndrome),
        .parity   (tup_d.parity)
    );

    cn_min_tree #(.DEGREE(DEGREE), .MAG_W(MAG_W), .SEL_W(SEL_W)) u_tree (
        .mag_flat (msg_mag),
        .min1     (tup_d.min1),
        .min2     (tup_d.min2),
        .sel      (tup_d.sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tup_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                tup_q <= tup_d;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_parity = tup_q.parity;
    assign out_sel    = tup_q.sel;
    assign out_min1   = tup_q.min1;
    assign out_min2   = tup_q.min2;
endmodule

// File: rtl/minsum_chk_node_chk.sv
module minsum_chk_node_chk #(
    parameter int DEGREE = 6,
    parameter int MAG_W  = 5,
    parameter int SEL_W  = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [DEGREE-1:0]       msg_sign,
    input logic [DEGREE*MAG_W-1:0] msg_mag,
    input logic                    syndrome,
    input logic                    out_valid,
    input logic                    out_parity,
    input logic [SEL_W-1:0]        out_sel,
    input logic [MAG_W-1:0]        out_min1,
    input logic [MAG_W-1:0]        out_min2
);
    logic [DEGREE*MAG_W-1:0] mag_q;
    logic below_min1, below_min2, earlier_tie, sel_match;

    always_ff @(posedge clk) begin
        if (rst) mag_q <= '0;
        else if (in_valid) mag_q <= msg_mag;
    end

    always_comb begin
        below_min1  = 1'b0;
        below_min2  = 1'b0;
        earlier_tie = 1'b0;
        sel_match   = 1'b0;
        for (int j = 0; j < DEGREE; j++) begin
            if (mag_q[j*MAG_W +: MAG_W] < out_min1) below_min1 = 1'b1;
            if (j != int'(out_sel) && mag_q[j*MAG_W +: MAG_W] < out_min2) below_min2 = 1'b1;
            if (j < int'(out_sel) && mag_q[j*MAG_W +: MAG_W] == out_min1) earlier_tie = 1'b1;
            if (j == int'(out_sel) && mag_q[j*MAG_W +: MAG_W] == out_min1) sel_match = 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid && out_min1 == '0 && out_min2 == '0 && out_sel == '0 && !out_parity);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_parity == ($past(^msg_sign) ^ $past(syndrome)));

    // R4
    min1_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !below_min1);

    // R5
    sel_points_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sel_match && !earlier_tie);

    // R6
    min2_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_min1 <= out_min2 && !below_min2);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_min1) && $stable(out_min2)
                      && $stable(out_sel) && $stable(out_parity));
endmodule

bind minsum_chk_node minsum_chk_node_chk #(
    .DEGREE(DEGREE), .MAG_W(MAG_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .msg_sign(msg_sign),
    .msg_mag(msg_mag), .syndrome(syndrome), .out_valid(out_valid),
    .out_parity(out_parity), .out_sel(out_sel), .out_min1(out_min1),
    .out_min2(out_min2)
);

// File: tb/minsum_chk_node_test.sv
`timescale 1ns/1ps
module minsum_chk_node_test;
    localparam int DEG = 6;
    localparam int MW  = 5;
    localparam int SW  = 3;
    localparam logic [MW-1:0] FULL = {MW{1'b1}};

    typedef struct {
        logic        parity;
        int          sel;
        logic [MW-1:0] min1;
        logic [MW-1:0] min2;
        int          stamp;
        string       tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [DEG-1:0]     msg_sign = '0;
    logic [DEG*MW-1:0]  msg_mag = '0;
    logic               syndrome = 1'b0;
    logic               out_valid, out_parity;
    logic [SW-1:0]      out_sel;
    logic [MW-1:0]      out_min1, out_min2;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0, mon_on = 1'b0, have_last = 1'b0;
    exp_t exp_q[$];
    exp_t last;

    minsum_chk_node #(.DEGREE(DEG), .MAG_W(MW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .msg_sign(msg_sign),
        .msg_mag(msg_mag), .syndrome(syndrome), .out_valid(out_valid),
        .out_parity(out_parity), .out_sel(out_sel), .out_min1(out_min1),
        .out_min2(out_min2)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [DEG*MW-1:0] pk(input int e0, input int e1, input int e2,
                                             input int e3, input int e4, input int e5);
        return {MW'(e5), MW'(e4), MW'(e3), MW'(e2), MW'(e1), MW'(e0)};
    endfunction

    // Called right after a falling edge; returns at the next falling edge.
    task automatic drive(input logic [DEG-1:0] s, input logic [DEG*MW-1:0] m,
                         input logic syn, input string tag);
        exp_t e;
        logic [MW-1:0] v;
        e.min1 = FULL; e.sel = 0; e.min2 = FULL;
        for (int i = 0; i < DEG; i++) begin
            v = m[i*MW +: MW];
            if (v < e.min1) begin e.min1 = v; e.sel = i; end
        end
        for (int i = 0; i < DEG; i++) begin
            v = m[i*MW +: MW];
            if (i != e.sel && v < e.min2) e.min2 = v;
        end
        e.parity = (^s) ^ syn;
        e.stamp  = cyc;
        e.tag    = tag;
        exp_q.push_back(e);
        in_valid = 1'b1; msg_sign = s; msg_mag = m; syndrome = syn;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        msg_sign = '1; msg_mag = '0; syndrome = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && !done) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected out_valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.stamp + 1 == cyc, "R2", "tuple latency", cyc - e.stamp, 1);
                        check(out_parity == e.parity, "R3", {e.tag, " parity"}, int'(out_parity), int'(e.parity));
                        check(out_min1 == e.min1, "R4", {e.tag, " min1"}, int'(out_min1), int'(e.min1));
                        check(int'(out_sel) == e.sel, "R5", {e.tag, " sel"}, int'(out_sel), e.sel);
                        check(out_min2 == e.min2, "R6", {e.tag, " min2"}, int'(out_min2), int'(e.min2));
                        last = e; have_last = 1'b1;
                    end
                end else begin
                    if (exp_q.size() != 0 && exp_q[0].stamp + 1 == cyc)
                        check(1'b0, "R2", "missing out_valid", 0, 1);
                    if (have_last) begin
                        check(out_min1 == last.min1 && out_min2 == last.min2 &&
                              int'(out_sel) == last.sel && out_parity == last.parity,
                              "R8", "held tuple min1", int'(out_min1), int'(last.min1));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: garbage with in_valid high during reset must not show
        in_valid = 1'b1; msg_sign = 6'b101010; msg_mag = pk(7, 3, 9, 1, 4, 2); syndrome = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && out_min1 == 0 && out_min2 == 0 && out_sel == 0 && !out_parity,
              "R1", "outputs in reset", int'(out_valid), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && out_min1 == 0 && out_min2 == 0 && out_sel == 0 && !out_parity,
              "R1", "outputs after reset", int'(out_min1), 0);
        mon_on = 1'b1;

        drive(6'b000000, pk(1, 2, 3, 4, 5, 6), 1'b0, "R4 ascending");
        drive(6'b000001, pk(20, 17, 12, 9, 4, 2), 1'b0, "R5 descending");
        drive(6'b110000, pk(14, 22, 3, 18, 5, 30), 1'b1, "R6 mid minimum");
        idle(3);
        drive(6'b000000, pk(9, 8, 7, 6, 5, 0), 1'b0, "R5 last edge");
        drive(6'b011010, pk(8, 6, 3, 12, 3, 9), 1'b0, "R5 R6 tie");
        drive(6'b111111, pk(11, 11, 11, 11, 11, 11), 1'b1, "R6 all equal");
        drive(6'b000000, pk(0, 0, 0, 0, 0, 0), 1'b1, "R6 all zero");
        idle(2);
        drive(6'b010101, pk(31, 31, 31, 31, 31, 31), 1'b0, "R9 full scale");
        drive(6'b000000, pk(31, 31, 31, 31, 31, 30), 1'b0, "R9 near full");
        // R7: same magnitudes, different signs and syndrome
        drive(6'b000000, pk(13, 7, 21, 7, 2, 19), 1'b0, "R7 signs a");
        drive(6'b101101, pk(13, 7, 21, 7, 2, 19), 1'b1, "R7 signs b");
        drive(6'b111111, pk(13, 7, 21, 7, 2, 19), 1'b0, "R7 signs c");
        idle(4);
        for (int k = 0; k < 400; k++) begin
            logic [DEG*MW-1:0] m;
            int hi;
            hi = (k % 3 == 0) ? 3 : 31;
            for (int i = 0; i < DEG; i++) m[i*MW +: MW] = MW'($urandom_range(0, hi));
            drive(DEG'($urandom), m, 1'($urandom), "R3 R4 R5 R6 random");
            if (k % 7 == 0) idle(1 + k % 3);
        end
        idle(3);
        check(exp_q.size() == 0, "R2", "outstanding tuples", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule